// File: doc/BRIEF.md
# Multi-level Haar wavelet block transformer

This block takes one 16x16 tile of colour samples, three 8-bit unsigned components per sample, and decomposes each component separately with an unnormalised two-dimensional Haar transform. Each pass splits the current working band into four subbands: one scaling (low-low) band and three detail bands. Only the scaling band is carried into the next pass. The number of passes is chosen per tile, from zero to four. Every coefficient of every pass is streamed out with tags, so a later matching stage can work at any resolution it needs.

A tile is taken in by pulsing `start` with the wanted pass count on `level_cfg`. The 256 samples are then pushed in over a valid/ready handshake. Once the last sample is taken, the block emits one coefficient per clock and raises `done` with the final coefficient. The three components share one arithmetic path and take turns on it. Until `done`, the block refuses new samples.

Top module: `haar_block_xform`

## Requirements
- R1: After a `start` pulse taken while idle, `in_ready` is high from the next cycle until 256 samples have been accepted. Samples fill the tile row by row, with the column index varying fastest. `in_ready` is low at all other times, including the whole time coefficients are being emitted.
- R2: `level_cfg` is captured on the accepted `start`. Any value above 4 is treated as 4.
- R3: For a 2x2 group with a at top-left, b at top-right, c at bottom-left and d at bottom-right, the scaling coefficient (subband code 0) is a+b+c+d. It is never negative.
- R4: The detail coefficients are a+b-c-d (subband code 1), a-b+c-d (code 2) and a-b-c+d (code 3). They are emitted as 18-bit two's complement values, with no overflow for any input.
- R5: Pass n works only on the scaling band left by pass n-1. Each pass halves the side of the band, so each subband holds 64, 16, 4 and 1 coefficients in passes 1 to 4.
- R6: Output order is: component 0, 1, 2 (`out_chan`) as the outermost loop, then pass ascending, then subbands 1, 2, 3, 0, then the group position in row-major order. `out_lvl` carries the pass number minus one and `out_sub` carries the subband code.
- R7: With a pass count of zero, each component emits its 256 samples unchanged in row-major order, tagged with level 0 and subband 0.
- R8: `done` is high for exactly the one cycle that carries the tile's final coefficient. No coefficient appears in the cycle after it.
- R9: While reset is held, and after it, `in_ready`, `out_valid` and `done` are low. A reset in the middle of a tile abandons that tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a tile when idle |
| level_cfg | input | 3 | Pass count for the tile (0..4, larger clamps) |
| in_valid | input | 1 | Sample on `in_pix` is valid |
| in_pix | input | 24 | Component 0 in bits 7:0, 1 in 15:8, 2 in 23:16 |
| in_ready | output | 1 | Block takes a sample this cycle if valid |
| out_valid | output | 1 | Coefficient on the output is valid |
| out_coef | output | 18 | Signed coefficient |
| out_chan | output | 2 | Component index |
| out_lvl | output | 2 | Pass number minus one |
| out_sub | output | 2 | Subband code |
| done | output | 1 | Final coefficient of the tile |

## Verification
Tiles are driven with four input patterns. A saturated flat tile checks the largest scaling sums and checks that every detail band is zero. A row-major ramp separates the horizontal detail from the vertical one, so a swapped a/b/c/d corner shows up. A checkerboard shows up only in the diagonal detail. A scrambled tile that differs per component catches component mix-ups and wrong band feedback between passes. Each pattern runs at several pass counts, including zero and a clamped over-range setting, and once after a reset taken mid-tile.

// File: rtl/haar_pkg.sv
package haar_pkg;
  typedef enum logic [1:0] {
    SB_LL   = 2'd0,
    SB_ROW  = 2'd1,
    SB_COL  = 2'd2,
    SB_DIAG = 2'd3
  } subband_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2
  } phase_t;
endpackage

// File: rtl/haar_butterfly.sv
module haar_butterfly
  import haar_pkg::*;
#(
  parameter int CW = 18
) (
  input  logic signed [CW-1:0] a,
  input  logic signed [CW-1:0] b,
  input  logic signed [CW-1:0] c,
  input  logic signed [CW-1:0] d,
  input  subband_t             sel,
  output logic signed [CW-1:0] y
);
  logic signed [CW-1:0] top_sum, top_dif, bot_sum, bot_dif;

  always_comb begin
    top_sum = a + b;
    top_dif = a - b;
    bot_sum = c + d;
    bot_dif = c - d;
    case (sel)
      SB_LL:   y = top_sum + bot_sum;
      SB_ROW:  y = top_sum - bot_sum;
      SB_COL:  y = top_dif + bot_dif;
      SB_DIAG: y = top_dif - bot_dif;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/haar_sample_store.sv
module haar_sample_store #(
  parameter int CH    = 3,
  parameter int DEPTH = 256,
  parameter int CW    = 18,
  parameter int AW    = 8,
  parameter int CHW   = 2
) (
  input  logic                   clk,
  input  logic [CH-1:0]          we,
  input  logic [AW-1:0]          waddr,
  input  logic [CH-1:0][CW-1:0]  wdata,
  input  logic [CHW-1:0]         rch,
  input  logic [3:0][AW-1:0]     raddr,
  output logic [3:0][CW-1:0]     rdata
);
  logic [CH-1:0][3:0][CW-1:0] bank_rd;

  for (genvar g = 0; g < CH; g++) begin : g_bank
    logic [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g];
    end

    for (genvar p = 0; p < 4; p++) begin : g_port
      assign bank_rd[g][p] = mem[raddr[p]];
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < CH; g++) begin
      if (rch == CHW'(g)) rdata = bank_rd[g];
    end
  end
endmodule

// File: rtl/haar_block_xform.sv
module haar_block_xform
  import haar_pkg::*;
#(
  parameter int SIDE   = 16,
  parameter int SW     = 8,
  parameter int CH     = 3,
  parameter int MAXLVL = 4,
  parameter int LVLW   = 3,
  parameter int CW     = SW + 2 * MAXLVL + 2,
  parameter int CHW    = $clog2(CH),
  parameter int TAGW   = $clog2(MAXLVL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LVLW-1:0]      level_cfg,
  input  logic                 in_valid,
  input  logic [CH*SW-1:0]     in_pix,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic signed [CW-1:0] out_coef,
  output logic [CHW-1:0]       out_chan,
  output logic [TAGW-1:0]      out_lvl,
  output logic [1:0]           out_sub,
  output logic                 done
);
  localparam int AW  = $clog2(SIDE * SIDE);
  localparam int PW  = $clog2(SIDE);
  localparam int LCW = $clog2(MAXLVL + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  phase_t          phase_q, phase_d;
  logic [LCW-1:0]  cfg_q, cfg_d, lvl_q, lvl_d;
  logic [AW-1:0]   fill_q, fill_d;
  logic [CHW-1:0]  chan_q, chan_d;
  logic [1:0]      step_q, step_d;
  logic [PW-1:0]   gi_q, gi_d, gj_q, gj_d, lim;
  logic            pass, last_step;
  subband_t        sub;
  int              r0, c0;

  logic [3:0][AW-1:0]       raddr;
  logic [3:0][CW-1:0]       rdata;
  logic [CH-1:0]            we;
  logic [AW-1:0]            waddr;
  logic [CH-1:0][CW-1:0]    wdata;
  logic signed [CW-1:0]     bf_y;

  logic                 ov_q, last_q;
  logic signed [CW-1:0] coef_q;
  logic [CHW-1:0]       ochan_q;
  logic [TAGW-1:0]      olvl_q;
  logic [1:0]           osub_q;

  assign pass = (cfg_q == '0);
  assign sub  = subband_t'(step_q + 2'd1);
  assign lim  = pass ? PW'(SIDE - 1) : PW'((SIDE >> lvl_q) - 1);

  always_comb begin
    r0 = pass ? int'(gi_q) : 2 * int'(gi_q);
    c0 = pass ? int'(gj_q) : 2 * int'(gj_q);
    raddr[0] = AW'(r0 * SIDE + c0);
    raddr[1] = AW'(r0 * SIDE + c0 + 1);
    raddr[2] = AW'((r0 + 1) * SIDE + c0);
    raddr[3] = AW'((r0 + 1) * SIDE + c0 + 1);
  end

  haar_sample_store #(
    .CH(CH), .DEPTH(SIDE * SIDE), .CW(CW), .AW(AW), .CHW(CHW)
  ) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .rch(chan_q), .raddr(raddr), .rdata(rdata)
  );

  haar_butterfly #(.CW(CW)) u_bfly (
    .a(rdata[0]), .b(rdata[1]), .c(rdata[2]), .d(rdata[3]),
    .sel(sub), .y(bf_y)
  );

  // write port: tile fill, or in-place scaling write-back
  always_comb begin
    we    = '0;
    waddr = fill_q;
    for (int g = 0; g < CH; g++) begin
      wdata[g] = {{(CW - SW){1'b0}}, in_pix[g*SW +: SW]};
    end
    if (phase_q == ST_FILL) begin
      we = {CH{in_valid}};
    end else if (phase_q == ST_RUN && !pass && sub == SB_LL) begin
      waddr = AW'(int'(gi_q) * SIDE + int'(gj_q));
      for (int g = 0; g < CH; g++) begin
        wdata[g] = bf_y;
        we[g]    = (chan_q == CHW'(g));
      end
    end
  end

  assign last_step = (phase_q == ST_RUN) && (chan_q == CHW'(CH - 1)) &&
                     (pass || (lvl_q == cfg_q && step_q == 2'd3)) &&
                     (gi_q == lim) && (gj_q == lim);

  // next-state logic
  always_comb begin
    phase_d = phase_q; cfg_d = cfg_q; fill_d = fill_q; chan_d = chan_q;
    lvl_d = lvl_q; step_d = step_q; gi_d = gi_q; gj_d = gj_q;
    case (phase_q)
      ST_IDLE: if (start) begin
        phase_d = ST_FILL;
        fill_d  = '0;
        cfg_d   = (level_cfg > LVLW'(MAXLVL)) ? LCW'(MAXLVL) : LCW'(level_cfg);
      end
      ST_FILL: if (in_valid) begin
        fill_d = fill_q + 1'b1;
        if (fill_q == AW'(SIDE * SIDE - 1)) begin
          phase_d = ST_RUN;
          chan_d  = '0;
          lvl_d   = (cfg_q == '0) ? '0 : LCW'(1);
          step_d  = '0;
          gi_d    = '0;
          gj_d    = '0;
        end
      end
      ST_RUN: begin
        if (gj_q != lim) gj_d = gj_q + 1'b1;
        else begin
          gj_d = '0;
          if (gi_q != lim) gi_d = gi_q + 1'b1;
          else begin
            gi_d = '0;
            if (!pass && step_q != 2'd3) step_d = step_q + 1'b1;
            else begin
              step_d = '0;
              if (!pass && lvl_q != cfg_q) lvl_d = lvl_q + 1'b1;
              else begin
                lvl_d = pass ? '0 : LCW'(1);
                if (chan_q != CHW'(CH - 1)) chan_d = chan_q + 1'b1;
                else                        phase_d = ST_IDLE;
              end
            end
          end
        end
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= ST_IDLE; cfg_q <= '0; fill_q <= '0; chan_q <= '0;
      lvl_q <= '0; step_q <= '0; gi_q <= '0; gj_q <= '0;
      ov_q <= 1'b0; last_q <= 1'b0; coef_q <= '0;
      ochan_q <= '0; olvl_q <= '0; osub_q <= '0;
    end else begin
      phase_q <= phase_d; cfg_q <= cfg_d; fill_q <= fill_d; chan_q <= chan_d;
      lvl_q <= lvl_d; step_q <= step_d; gi_q <= gi_d; gj_q <= gj_d;
      ov_q   <= (phase_q == ST_RUN);
      last_q <= last_step;
      if (phase_q == ST_RUN) begin
        coef_q  <= pass ? signed'(rdata[0]) : bf_y;
        ochan_q <= chan_q;
        olvl_q  <= pass ? '0 : TAGW'(lvl_q - LCW'(1));
        osub_q  <= pass ? SB_LL : sub;
      end
    end
  end

  assign in_ready  = (phase_q == ST_FILL);
  assign out_valid = ov_q;
  assign out_coef  = coef_q;
  assign out_chan  = ochan_q;
  assign out_lvl   = olvl_q;
  assign out_sub   = osub_q;
  assign done      = ov_q & last_q;
endmodule

// File: rtl/haar_block_xform_chk.sv
module haar_block_xform_chk #(
  parameter int CW   = 18,
  parameter int CHW  = 2,
  parameter int TAGW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic signed [CW-1:0] out_coef,
  input logic [CHW-1:0]       out_chan,
  input logic [TAGW-1:0]      out_lvl,
  input logic [1:0]           out_sub,
  input logic                 done
);
  assert_no_intake_while_emit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_scaling_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sub == 2'd0) |-> !out_coef[CW-1]);

  assert_level_ascends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && out_chan == $past(out_chan)) |-> (out_lvl >= $past(out_lvl)));

  assert_chan_ascends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_chan >= $past(out_chan)));

  assert_done_with_coef_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);
endmodule

bind haar_block_xform haar_block_xform_chk #(.CW(CW), .CHW(CHW), .TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_coef(out_coef), .out_chan(out_chan), .out_lvl(out_lvl),
  .out_sub(out_sub), .done(done)
);

// File: tb/haar_block_xform_test.sv
module haar_block_xform_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  level_cfg;
  logic        in_valid;
  logic [23:0] in_pix;
  logic        in_ready, out_valid, done;
  logic signed [17:0] out_coef;
  logic [1:0]  out_chan, out_lvl, out_sub;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int done_at  = 0;
  logic [23:0] got_q[$];
  logic [23:0] exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  haar_block_xform uut (
    .clk(clk), .rst_n(rst_n), .start(start), .level_cfg(level_cfg),
    .in_valid(in_valid), .in_pix(in_pix), .in_ready(in_ready),
    .out_valid(out_valid), .out_coef(out_coef), .out_chan(out_chan),
    .out_lvl(out_lvl), .out_sub(out_sub), .done(done)
  );

  // {pattern[3:0], level setting[3:0], coefficients per component[11:0]}
  localparam int NCASE = 8;
  localparam logic [19:0] CASES [NCASE] = '{
    {4'd1, 4'd4, 12'd340}, {4'd0, 4'd4, 12'd340}, {4'd2, 4'd1, 12'd256},
    {4'd3, 4'd2, 12'd320}, {4'd1, 4'd3, 12'd336}, {4'd3, 4'd0, 12'd256},
    {4'd3, 4'd7, 12'd340}, {4'd2, 4'd4, 12'd340}
  };

  function automatic int pix(int pat, int ch, int x, int y);
    case (pat)
      0: return 255;
      1: return (x + 16 * y + 7 * ch) & 255;
      2: return (((x ^ y) & 1) != 0) ? 200 - 10 * ch : 5 * ch;
      default: return (x * 37 + y * 91 + ch * 53 + x * y) & 255;
    endcase
  endfunction

  task automatic check(input string req, input logic ok, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (out_valid) got_q.push_back({out_chan, out_lvl, out_sub, out_coef});
    if (done) begin
      done_cnt++;
      done_at = got_q.size();
    end
  end

  task automatic build_expected(input int pat, input int cfg);
    int w[16][16];
    int nw[16][16];
    int lv;
    lv = (cfg > 4) ? 4 : cfg;
    exp_q.delete();
    for (int ch = 0; ch < 3; ch++) begin
      for (int y = 0; y < 16; y++)
        for (int x = 0; x < 16; x++) w[y][x] = pix(pat, ch, x, y);
      if (lv == 0) begin
        for (int y = 0; y < 16; y++)
          for (int x = 0; x < 16; x++)
            exp_q.push_back({2'(ch), 2'd0, 2'd0, 18'(w[y][x])});
      end
      for (int l = 1; l <= lv; l++) begin
        int h;
        h = 16 >> l;
        for (int k = 0; k < 4; k++) begin
          int s;
          s = (k + 1) % 4;
          for (int i = 0; i < h; i++)
            for (int j = 0; j < h; j++) begin
              int a, b, c, d, v;
              a = w[2*i][2*j];   b = w[2*i][2*j+1];
              c = w[2*i+1][2*j]; d = w[2*i+1][2*j+1];
              case (s)
                0: v = a + b + c + d;
                1: v = a + b - c - d;
                2: v = a - b + c - d;
                default: v = a - b - c + d;
              endcase
              if (s == 0) nw[i][j] = v;
              exp_q.push_back({2'(ch), 2'(l - 1), 2'(s), 18'(v)});
            end
        end
        for (int i = 0; i < h; i++)
          for (int j = 0; j < h; j++) w[i][j] = nw[i][j];
      end
    end
  endtask

  task automatic start_block(input int cfg);
    @(negedge clk);
    start = 1'b1;
    level_cfg = 3'(cfg);
    @(negedge clk);
    start = 1'b0;
    check("R1 ready after start", in_ready == 1'b1, in_ready, 1);
  endtask

  task automatic fill_block(input int pat);
    int idx;
    idx = 0;
    while (idx < 256) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int ch = 0; ch < 3; ch++)
        in_pix[ch*8 +: 8] = 8'(pix(pat, ch, idx % 16, idx / 16));
      if (in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_case(input int pat, input int cfg, input int per_ch);
    build_expected(pat, cfg);
    got_q.delete();
    done_cnt = 0;
    start_block(cfg);
    fill_block(pat);
    while (!out_valid) @(negedge clk);
    check("R1 ready low while emitting", in_ready == 1'b0, in_ready, 0);
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R5 coefficient count", got_q.size() == 3 * per_ch, got_q.size(), 3 * per_ch);
    check("R5 model count", exp_q.size() == 3 * per_ch, exp_q.size(), 3 * per_ch);
    check("R8 single done", done_cnt == 1, done_cnt, 1);
    check("R8 done on final coefficient", done_at == exp_q.size(), done_at, exp_q.size());
    for (int n = 0; n < exp_q.size() && n < got_q.size(); n++) begin
      logic [23:0] e, g;
      string req;
      e = exp_q[n];
      g = got_q[n];
      if (g[23:18] != e[23:18])      req = "R6 tag";
      else if (cfg == 0)             req = "R7 passthrough";
      else if (cfg > 4 && n == 0)    req = "R2 clamp";
      else if (e[21:20] != 2'd0)     req = "R5 later level";
      else if (e[19:18] == 2'd0)     req = "R3 scaling";
      else                           req = "R4 detail";
      check(req, g == e, longint'(g), longint'(e));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; level_cfg = '0; in_valid = 1'b0; in_pix = '0;
    repeat (3) @(negedge clk);
    check("R9 reset in_ready", in_ready == 1'b0, in_ready, 0);
    check("R9 reset out_valid", out_valid == 1'b0, out_valid, 0);
    check("R9 reset done", done == 1'b0, done, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle not ready", in_ready == 1'b0, in_ready, 0);

    for (int t = 0; t < NCASE; t++) begin
      run_case(int'(CASES[t][19:16]), int'(CASES[t][15:12]), int'(CASES[t][11:0]));
    end

    // directed: reset in the middle of a tile, then recovery
    start_block(4);
    fill_block(1);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid-tile reset out_valid", out_valid == 1'b0, out_valid, 0);
    check("R9 mid-tile reset in_ready", in_ready == 1'b0, in_ready, 0);
    check("R9 mid-tile reset done", done == 1'b0, done, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 idle after reset", out_valid == 1'b0, out_valid, 0);
    run_case(2, 2, 320);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule